// File: doc/BRIEF.md
# Set/Clear GPIO Pin Controller

This block is a 32-pin general-purpose I/O controller on an APB-style register bus. Each pin has an output data latch and a direction latch. Software never writes either latch directly. It changes them through dedicated write-one-to-set and write-one-to-clear addresses, so it can alter one pin without a read-modify-write that races against other writers.

Each pin also carries four configuration bits:

- a pull-disable bit;
- a sleep-retain bit;
- a two-bit alternate-function code, made of one bit from a "function A" register and one from a "function B" register.

The pull direction has no bit of its own. It reuses the output data latch: while a pin is an input, a data bit of 1 pulls the pin up and 0 pulls it down. When the chip-level `sleep_req` input is high, every pin whose sleep-retain bit is 0 becomes an input with its pull forced on. Pins whose sleep-retain bit is 1 keep their configuration. Pin levels reach the data read register through a two-flop synchronizer.

Top module: `sc_gpio_ctrl`

## Requirements
- R1: After reset every latch is 0. So `pad_oe` is 0, `pad_out` is 0, `pull_en` is all ones, `pull_up` is 0 and `alt_sel` is 0, and every register reads 0 while the pins are low.
- R2: A write to byte offset 0x04 sets each data latch bit whose write-data bit is 1 and leaves the other bits unchanged. Reads of 0x04 and 0x08 return the data latch, which drives `pad_out`.
- R3: A write to byte offset 0x08 clears each data latch bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: A write to 0x14 sets direction bits and a write to 0x18 clears them, both on write-data ones. A direction bit of 1 means output. Offsets 0x10, 0x14 and 0x18 read the direction latch. A write to 0x10 has no effect. Outside sleep, `pad_oe` equals the direction latch.
- R5: Offset 0x00 reads the pin levels through a two-flop synchronizer. A change on `pin_in` before a rising edge is visible to a read only after the second rising edge. A write to 0x00 has no effect.
- R6: Offset 0x0C holds the pull-disable bits. `pull_en[i]` is 1 only when the pin is not driving and its pull is enabled (pull-disable bit 0, or the pin is forced into sleep). `pull_up[i]` equals data latch bit i.
- R7: Offset 0x20 holds function-A bits and offset 0x24 holds function-B bits. `alt_sel[2i]` is the A bit of pin i and `alt_sel[2i+1]` is its B bit. Code 00 is plain GPIO, 01 is function A, 10 is function B and 11 is the third function.
- R8: Offset 0x1C holds the sleep-retain bits. While `sleep_req` is 1, a pin with retain bit 0 has `pad_oe` 0 and `pull_en` 1, and a pin with retain bit 1 keeps its normal outputs.
- R9: Offsets above 0x24, and addresses with either of the two low bits set, read 0 and ignore writes.
- R10: A write takes effect only in the access phase (`psel`, `penable` and `pwrite` all 1). It is visible on the outputs after that rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 6 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while selected |
| sleep_req | input | 1 | Chip sleep request |
| pin_in | input | 32 | Sampled pad levels, asynchronous |
| pad_out | output | 32 | Pad output value |
| pad_oe | output | 32 | Pad output enable |
| pull_en | output | 32 | Pull resistor enable |
| pull_up | output | 32 | Pull direction, 1 up and 0 down |
| alt_sel | output | 64 | Function code per pin, {B,A} at bits 2i+1:2i |

## Verification
The bench checks the set and clear addresses against random masks, using latches that already hold a random value. A design that wrote the mask straight into the latch would wipe out the bits that should be untouched.

It reads the data register one edge and two edges after a pin change. A design with one synchronizer stage too few or too many would show the new level a cycle early or a cycle late.

During sleep, it mixes retained pins with forced pins, and output pins with input pins. A design that forced every pin, or left the pull on for a pin that is driving, would show wrong `pad_oe` or `pull_en` bits.

It also writes to the read-only offset 0x00, the read-only offset 0x10, misaligned addresses and unmapped addresses. A design that decoded these loosely would alter a latch.

// File: rtl/sc_gpio_pkg.sv
package sc_gpio_pkg;

    localparam int NPINS   = 32;
    localparam int ADDR_W  = 6;
    localparam int IDX_W   = ADDR_W - 2;
    localparam int ALT_W   = 2;
    localparam int SYNC_N  = 2;

    // word index of each register; order sets the byte offset (index * 4)
    typedef enum logic [IDX_W-1:0] {
        IX_LEVEL   = 4'd0,
        IX_OSET    = 4'd1,
        IX_OCLR    = 4'd2,
        IX_NOPULL  = 4'd3,
        IX_DIR     = 4'd4,
        IX_DSET    = 4'd5,
        IX_DCLR    = 4'd6,
        IX_RETAIN  = 4'd7,
        IX_FUNA    = 4'd8,
        IX_FUNB    = 4'd9
    } reg_idx_e;

    localparam logic [IDX_W-1:0] IDX_LAST = IX_FUNB;

    typedef logic [NPINS-1:0] pinvec_t;

    typedef struct packed {
        pinvec_t dat;
        pinvec_t dir;
        pinvec_t nopull;
        pinvec_t retain;
        pinvec_t funa;
        pinvec_t funb;
    } cfg_t;

    typedef enum logic [ALT_W-1:0] {
        FN_GPIO  = 2'b00,
        FN_A     = 2'b01,
        FN_B     = 2'b10,
        FN_THIRD = 2'b11
    } fn_e;

    typedef struct packed {
        logic oe;
        logic out;
        logic pen;
        logic pup;
        fn_e  fn;
    } pad_t;

    function automatic pinvec_t apply_set(pinvec_t cur, pinvec_t mask);
        return cur | mask;
    endfunction

    function automatic pinvec_t apply_clr(pinvec_t cur, pinvec_t mask);
        return cur & ~mask;
    endfunction

    // resolve one pin's pad controls from its configuration bits
    function automatic pad_t pad_resolve(logic dat, logic dir, logic nopull,
                                         logic retain, logic fa, logic fb,
                                         logic sleep);
        pad_t p;
        logic forced;
        forced = sleep & ~retain;
        p.oe   = dir & ~forced;
        p.out  = dat;
        p.pen  = ~p.oe & (~nopull | forced);
        p.pup  = dat;
        p.fn   = fn_e'({fb, fa});
        return p;
    endfunction

endpackage

// File: rtl/sc_gpio_sync.sv
module sc_gpio_sync
    import sc_gpio_pkg::*;
#(
    parameter int WIDTH  = NPINS,
    parameter int STAGES = SYNC_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/sc_gpio_regs.sv
module sc_gpio_regs
    import sc_gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [NPINS-1:0]  pwdata,
    input  pinvec_t           pin_sync,
    output logic [NPINS-1:0]  prdata,
    output cfg_t              cfg
);

    logic             wr_en;
    logic             hit;
    logic [IDX_W-1:0] idx_raw;
    reg_idx_e         idx;
    cfg_t             cfg_q;

    assign idx_raw = paddr[ADDR_W-1:2];
    assign idx     = reg_idx_e'(idx_raw);
    assign hit     = (paddr[1:0] == 2'b00) && (idx_raw <= IDX_LAST);
    assign wr_en   = psel & penable & pwrite & hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            case (idx)
                IX_OSET:   cfg_q.dat    <= apply_set(cfg_q.dat, pwdata);
                IX_OCLR:   cfg_q.dat    <= apply_clr(cfg_q.dat, pwdata);
                IX_NOPULL: cfg_q.nopull <= pwdata;
                IX_DSET:   cfg_q.dir    <= apply_set(cfg_q.dir, pwdata);
                IX_DCLR:   cfg_q.dir    <= apply_clr(cfg_q.dir, pwdata);
                IX_RETAIN: cfg_q.retain <= pwdata;
                IX_FUNA:   cfg_q.funa   <= pwdata;
                IX_FUNB:   cfg_q.funb   <= pwdata;
                default:   cfg_q        <= cfg_q;
            endcase
        end
    end

    always_comb begin
        prdata = '0;
        if (hit) begin
            case (idx)
                IX_LEVEL:                   prdata = pin_sync;
                IX_OSET, IX_OCLR:           prdata = cfg_q.dat;
                IX_NOPULL:                  prdata = cfg_q.nopull;
                IX_DIR, IX_DSET, IX_DCLR:   prdata = cfg_q.dir;
                IX_RETAIN:                  prdata = cfg_q.retain;
                IX_FUNA:                    prdata = cfg_q.funa;
                IX_FUNB:                    prdata = cfg_q.funb;
                default:                    prdata = '0;
            endcase
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/sc_gpio_padctl.sv
module sc_gpio_padctl
    import sc_gpio_pkg::*;
(
    input  cfg_t                   cfg,
    input  logic                   sleep_req,
    output logic [NPINS-1:0]       pad_out,
    output logic [NPINS-1:0]       pad_oe,
    output logic [NPINS-1:0]       pull_en,
    output logic [NPINS-1:0]       pull_up,
    output logic [ALT_W*NPINS-1:0] alt_sel
);

    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_pin
            pad_t p;
            assign p = pad_resolve(cfg.dat[i], cfg.dir[i], cfg.nopull[i],
                                   cfg.retain[i], cfg.funa[i], cfg.funb[i],
                                   sleep_req);
            assign pad_out[i] = p.out;
            assign pad_oe[i]  = p.oe;
            assign pull_en[i] = p.pen;
            assign pull_up[i] = p.pup;
            assign alt_sel[ALT_W*i +: ALT_W] = p.fn;
        end
    endgenerate

endmodule

// File: rtl/sc_gpio_ctrl.sv
module sc_gpio_ctrl
    import sc_gpio_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   psel,
    input  logic                   penable,
    input  logic                   pwrite,
    input  logic [ADDR_W-1:0]      paddr,
    input  logic [NPINS-1:0]       pwdata,
    output logic [NPINS-1:0]       prdata,
    input  logic                   sleep_req,
    input  logic [NPINS-1:0]       pin_in,
    output logic [NPINS-1:0]       pad_out,
    output logic [NPINS-1:0]       pad_oe,
    output logic [NPINS-1:0]       pull_en,
    output logic [NPINS-1:0]       pull_up,
    output logic [ALT_W*NPINS-1:0] alt_sel
);

    pinvec_t pin_sync;
    cfg_t    cfg_q;

    sc_gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_N)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .d_async (pin_in),
        .q_sync  (pin_sync)
    );

    sc_gpio_regs regs_i (
        .clk      (clk),
        .rst      (rst),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .pwdata   (pwdata),
        .pin_sync (pin_sync),
        .prdata   (prdata),
        .cfg      (cfg_q)
    );

    sc_gpio_padctl padctl_i (
        .cfg       (cfg_q),
        .sleep_req (sleep_req),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pull_en   (pull_en),
        .pull_up   (pull_up),
        .alt_sel   (alt_sel)
    );

endmodule

// File: rtl/sc_gpio_ctrl_chk.sv
module sc_gpio_ctrl_chk
    import sc_gpio_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [NPINS-1:0]  pwdata,
    input logic              sleep_req,
    input logic [NPINS-1:0]  pad_out,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  pull_en,
    input logic [NPINS-1:0]  dir_q,
    input logic [NPINS-1:0]  retain_q
);

    logic acc_wr;
    assign acc_wr = psel && penable && pwrite;

    // R2: set address raises masked bits, keeps the rest
    a_r2_set_bits: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && paddr == 6'h04) |=>
            ((pad_out & $past(pwdata)) == $past(pwdata)) &&
            ((pad_out & ~$past(pwdata)) == ($past(pad_out) & ~$past(pwdata))));

    // R3: clear address lowers masked bits, keeps the rest
    a_r3_clr_bits: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && paddr == 6'h08) |=>
            ((pad_out & $past(pwdata)) == '0) &&
            ((pad_out & ~$past(pwdata)) == ($past(pad_out) & ~$past(pwdata))));

    // R4: direction set makes masked pins outputs
    a_r4_dir_set: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && paddr == 6'h14) |=>
            ((dir_q & $past(pwdata)) == $past(pwdata)));

    // R5: write to the level register changes nothing
    a_r5_level_ro: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && paddr == 6'h00 && $stable(sleep_req)) |=>
            ($stable(pad_out) && $stable(pad_oe) && $stable(pull_en)));

    // R6: a driving pin never has its pull on
    a_r6_no_pull_when_driving: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & pull_en) == '0);

    // R8: forced pins are inputs with pull on during sleep
    a_r8_sleep_forced: assert property (@(posedge clk) disable iff (rst)
        sleep_req |-> (((pad_oe & ~retain_q) == '0) &&
                       ((pull_en | retain_q) == '1)));

    // R9: unmapped or misaligned writes change nothing
    a_r9_unmapped_wr: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && (paddr > 6'h24 || paddr[1:0] != 2'b00) && $stable(sleep_req)) |=>
            ($stable(pad_out) && $stable(pad_oe) && $stable(pull_en)));

endmodule

bind sc_gpio_ctrl sc_gpio_ctrl_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .pwdata    (pwdata),
    .sleep_req (sleep_req),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pull_en   (pull_en),
    .dir_q     (cfg_q.dir),
    .retain_q  (cfg_q.retain)
);

// File: tb/sc_gpio_ctrl_tb_top.sv
`timescale 1ns/100ps
module sc_gpio_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        psel, penable, pwrite;
    logic [5:0]  paddr;
    logic [31:0] pwdata;
    logic [31:0] prdata;
    logic        sleep_req;
    logic [31:0] pin_in;
    logic [31:0] pad_out, pad_oe, pull_en, pull_up;
    logic [63:0] alt_sel;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // model state
    logic [31:0] m_dat, m_dir, m_nop, m_ret, m_fa, m_fb, m_pins;

    always #2.5 clk = ~clk;

    sc_gpio_ctrl dut_i (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .sleep_req(sleep_req),
        .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe), .pull_en(pull_en),
        .pull_up(pull_up), .alt_sel(alt_sel)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] e_forced();
        return sleep_req ? ~m_ret : 32'h0;
    endfunction
    function automatic logic [31:0] e_oe();
        return m_dir & ~e_forced();
    endfunction
    function automatic logic [31:0] e_pen();
        return ~e_oe() & (~m_nop | e_forced());
    endfunction
    function automatic logic [63:0] e_alt();
        logic [63:0] a;
        for (int i = 0; i < 32; i++) begin
            a[2*i]   = m_fa[i];
            a[2*i+1] = m_fb[i];
        end
        return a;
    endfunction
    function automatic logic [31:0] e_read(input logic [5:0] a);
        case (a)
            6'h00: return m_pins;
            6'h04, 6'h08: return m_dat;
            6'h0C: return m_nop;
            6'h10, 6'h14, 6'h18: return m_dir;
            6'h1C: return m_ret;
            6'h20: return m_fa;
            6'h24: return m_fb;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check_pads(input string tag);
        chk({tag, " pad_out"}, {32'h0, pad_out}, {32'h0, m_dat});
        chk({tag, " pad_oe"},  {32'h0, pad_oe},  {32'h0, e_oe()});
        chk({tag, " pull_en"}, {32'h0, pull_en}, {32'h0, e_pen()});
        chk({tag, " pull_up"}, {32'h0, pull_up}, {32'h0, m_dat});
        chk({tag, " alt_sel"}, alt_sel, e_alt());
    endtask

    task automatic model_write(input logic [5:0] a, input logic [31:0] d);
        case (a)
            6'h04: m_dat = m_dat | d;
            6'h08: m_dat = m_dat & ~d;
            6'h0C: m_nop = d;
            6'h14: m_dir = m_dir | d;
            6'h18: m_dir = m_dir & ~d;
            6'h1C: m_ret = d;
            6'h20: m_fa  = d;
            6'h24: m_fb  = d;
            default: ;
        endcase
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic read_check(input string tag, input logic [5:0] a);
        logic [31:0] v;
        bus_read(a, v);
        chk(tag, {32'h0, v}, {32'h0, e_read(a)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v1, v2, seed_v;
        seed_v = $urandom(32'h5eed_1234);
        rst = 1'b1; psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0;
        sleep_req = 0; pin_in = 0;
        m_dat = 0; m_dir = 0; m_nop = 0; m_ret = 0; m_fa = 0; m_fb = 0; m_pins = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check_pads("R1 reset");
        read_check("R1 reset dir", 6'h10);
        read_check("R1 reset level", 6'h00);
        read_check("R1 reset nopull", 6'h0C);

        // R2/R3 directed on a nonzero latch
        bus_write(6'h04, 32'hF0F0_00FF);
        check_pads("R2 set");
        bus_write(6'h04, 32'h0000_0F00);
        read_check("R2 set keeps others", 6'h04);
        bus_write(6'h08, 32'h8000_00F1);
        read_check("R3 clear keeps others", 6'h08);
        check_pads("R3 clear");

        // R4 direction, read-only 0x10
        bus_write(6'h14, 32'h0000_FFFF);
        bus_write(6'h10, 32'hFFFF_FFFF);
        read_check("R4 dir write ignored", 6'h10);
        check_pads("R4 dir set");
        bus_write(6'h18, 32'h0000_00F0);
        read_check("R4 dir clear", 6'h18);
        check_pads("R4 dir clear pads");

        // R5 synchronizer latency and read-only level
        @(negedge clk);
        pin_in = 32'hA5A5_3C3C;
        psel = 1'b1; pwrite = 1'b0; paddr = 6'h00; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 v1 = prdata;
        @(negedge clk);
        #1 v2 = prdata;
        psel = 1'b0; penable = 1'b0;
        chk("R5 one edge old", {32'h0, v1}, {32'h0, m_pins});
        m_pins = 32'hA5A5_3C3C;
        chk("R5 two edges new", {32'h0, v2}, {32'h0, m_pins});
        bus_write(6'h00, 32'hFFFF_FFFF);
        check_pads("R5 level write ignored");

        // R6 pull
        bus_write(6'h0C, 32'h00FF_00FF);
        check_pads("R6 pull");
        read_check("R6 nopull readback", 6'h0C);

        // R7 alt codes: all four per nibble
        bus_write(6'h20, 32'hAAAA_AAAA);
        bus_write(6'h24, 32'hCCCC_CCCC);
        check_pads("R7 alt codes");
        read_check("R7 funb readback", 6'h24);

        // R8 sleep with mixed retain
        bus_write(6'h1C, 32'h0F0F_0F0F);
        @(negedge clk); sleep_req = 1'b1; #1;
        check_pads("R8 sleep forced");
        @(negedge clk); sleep_req = 1'b0; #1;
        check_pads("R8 sleep released");

        // R9 unmapped and misaligned
        bus_write(6'h28, 32'hFFFF_FFFF);
        bus_write(6'h05, 32'hFFFF_FFFF);
        bus_write(6'h3C, 32'hFFFF_FFFF);
        check_pads("R9 unmapped writes ignored");
        read_check("R9 unmapped read", 6'h2C);
        read_check("R9 misaligned read", 6'h06);

        // R10 no write without access phase
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = 6'h04; pwdata = 32'hFFFF_FFFF; penable = 1'b0;
        @(negedge clk);
        psel = 1'b0;
        @(negedge clk);
        check_pads("R10 setup only no write");

        // random mix
        for (int k = 0; k < 400; k++) begin
            logic [5:0] a;
            logic [31:0] d;
            a = 6'((($urandom % 12) * 4));
            if (($urandom % 8) == 0) a = a | 6'h1;
            d = $urandom;
            bus_write(a, d);
            if (($urandom % 4) == 0) begin
                @(negedge clk); sleep_req = ~sleep_req; #1;
            end
            check_pads("R2 R3 R4 R6 R7 R8 random pads");
            if (($urandom % 3) == 0) read_check("R9 random readback", 6'((($urandom % 12) * 4)));
            if (($urandom % 16) == 0) begin
                @(negedge clk); pin_in = $urandom;
                repeat (2) @(negedge clk);
                m_pins = pin_in;
                read_check("R5 random level", 6'h00);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule